// File: doc/BRIEF.md
# Dead-Time Pulser Scaler Unit

This unit measures how much of the run an acquisition system spends busy. A divider on the system clock produces a steady one-cycle tick (10 kHz from a 40 MHz clock with the default divide ratio of 4000). The tick is counted twice. One count takes every tick. The other takes only the ticks that arrive while the busy/veto level is low. Software forms the dead-time fraction from the two counts. The pulser runs at a fixed rate, so the measurement does not suffer from the double counting that a raw-trigger ratio can pick up.

Next to the two pulser counts, the unit has one count of raw trigger pulses, one of accepted (live) trigger pulses, and one per trigger-source input. Every trigger and source input is edge-detected, so a level that stays high adds only one count.

All counters saturate. A latch command copies the whole bank into shadow registers on a single edge, which gives software a consistent snapshot. A clear command zeroes the running counters. Software reads the snapshot one word at a time through an index select.

Top module: `deadtime_scaler`

## Requirements
- R1: While `rst_n` is low, all counters, all shadow registers and `rd_data_o` are zero. After `rst_n` rises, the first two clock edges only release the internal reset. Counting starts on the third edge.
- R2: The pulser ticks on the PULSE_DIV-th active edge after reset release or after a clear, and every PULSE_DIV edges after that. The free pulser count, index 0, adds one on every tick.
- R3: The gated pulser count, index 1, adds one on a tick only if `veto_i` is low at that edge. It never exceeds the free count.
- R4: The raw trigger count, index 2, adds one on each rising edge of `raw_trig_i`. The live trigger count, index 3, adds one on each rising edge of `live_trig_i`.
- R5: Source channel i, index 4+i, adds one on each rising edge of `src_i[i]`. An input held high for many cycles adds exactly one.
- R6: At an edge where `latch_i` is high, every shadow register takes the value its counter held before that edge. At any other edge the shadows do not change. `rd_data_o` shows the shadow picked by `rd_sel_i`, combinationally.
- R7: At an edge where `clear_i` is high, every counter becomes zero and the pulser phase restarts. Increments at that edge are dropped and the shadows keep their values. If `latch_i` is high at the same edge, the shadows capture the values from before the clear.
- R8: A counter at 2^CNT_W-1 stays there and does not wrap.
- R9: A `rd_sel_i` value of 4+NUM_SRC or higher reads zero.
- R10: Edge detection keeps tracking inputs through a clear. An input that was already high before a clear adds nothing after the clear until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| veto_i | input | 1 | Busy/veto level; high blocks the gated pulser count |
| raw_trig_i | input | 1 | Raw trigger, counted on rising edges |
| live_trig_i | input | 1 | Accepted trigger, counted on rising edges |
| src_i | input | NUM_SRC | Trigger-source inputs, one counter each |
| clear_i | input | 1 | Zero all running counters and restart the pulser |
| latch_i | input | 1 | Copy all counters into the shadow bank |
| rd_sel_i | input | SEL_W | Shadow index: 0 free, 1 gated, 2 raw, 3 live, 4+i source i |
| rd_data_o | output | CNT_W | Selected shadow value |

## Verification
On every cycle, the assertions check four things:
- The gated pulser count never passes the free one, and it holds still while the veto is raised.
- A clear leaves zeroed counters.
- A saturated counter does not wrap.
- Shadows change only on a latch, and a latch captures the counter value from before the edge.

Other behaviour needs the bench's scenarios and its cycle-accurate model:
- the exact pulser period and phase after a clear;
- one count for a held level, including through a clear;
- a latch and a clear on the same edge;
- the two-edge reset release;
- zero reads for out-of-range indices.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int unsigned FIXED_CH = 4;
  typedef enum int unsigned {
    CH_PULSE_FREE  = 0,
    CH_PULSE_GATED = 1,
    CH_TRIG_RAW    = 2,
    CH_TRIG_LIVE   = 3
  } fixed_ch_e;
endpackage

// File: rtl/dts_pulser.sv
module dts_pulser #(
  parameter int unsigned DIV = 4000,
  localparam int unsigned DIV_W = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    tick_o = (div_q == DIV_W'(DIV - 1));
    if (restart_i || tick_o) div_d = '0;
    else                     div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/dts_edge.sv
module dts_edge #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  assign rise_o = lvl_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end
endmodule

// File: rtl/dts_sat_counter.sv
module dts_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  always_comb begin
    en    = clr_i | inc_i;
    cnt_d = cnt_q;
    if (clr_i)                   cnt_d = '0;
    else if (cnt_q != {W{1'b1}}) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/deadtime_scaler.sv
module deadtime_scaler
  import dts_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_SRC   = 16,
  parameter int unsigned PULSE_DIV = 4000,
  localparam int unsigned NUM_CNT  = FIXED_CH + NUM_SRC,
  localparam int unsigned SEL_W    = $clog2(NUM_CNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               veto_i,
  input  logic               raw_trig_i,
  input  logic               live_trig_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clear_i,
  input  logic               latch_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [CNT_W-1:0]   rd_data_o
);
  localparam int unsigned EDGE_W = NUM_SRC + 2;

  // reset: asserted asynchronously, released after two edges
  logic rst_s1_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q_n  <= rst_s1_q;
    end
  end

  logic              tick;
  logic [EDGE_W-1:0] rise;
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]  cnt_q   [NUM_CNT];
  logic [CNT_W-1:0]  shadow_q[NUM_CNT];

  dts_pulser #(.DIV(PULSE_DIV)) u_pulser (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .restart_i(clear_i),
    .tick_o   (tick)
  );

  dts_edge #(.W(EDGE_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_q_n),
    .lvl_i ({src_i, live_trig_i, raw_trig_i}),
    .rise_o(rise)
  );

  always_comb begin
    inc[CH_PULSE_FREE]  = tick;
    inc[CH_PULSE_GATED] = tick & ~veto_i;
    inc[CH_TRIG_RAW]    = rise[0];
    inc[CH_TRIG_LIVE]   = rise[1];
    inc[NUM_CNT-1:FIXED_CH] = rise[EDGE_W-1:2];
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ch
    dts_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_q_n),
      .clr_i(clear_i),
      .inc_i(inc[g]),
      .cnt_o(cnt_q[g])
    );

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)     shadow_q[g] <= '0;
      else if (latch_i) shadow_q[g] <= cnt_q[g];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if ({1'b0, rd_sel_i} < (SEL_W+1)'(NUM_CNT))
      rd_data_o = shadow_q[rd_sel_i];
  end
endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             clear_i,
  input logic             latch_i,
  input logic             veto_i,
  input logic [CNT_W-1:0] cnt_free,
  input logic [CNT_W-1:0] cnt_gated,
  input logic [CNT_W-1:0] cnt_raw,
  input logic [CNT_W-1:0] shd_raw
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_GATED_LE_FREE: assert property (@(posedge clk) disable iff (!rst_q_n)
    cnt_gated <= cnt_free); // R3
  AST_VETO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_q_n)
    veto_i && !clear_i |=> cnt_gated == $past(cnt_gated)); // R3
  AST_LATCH_COPIES: assert property (@(posedge clk) disable iff (!rst_q_n)
    latch_i |=> shd_raw == $past(cnt_raw)); // R6
  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !latch_i |=> $stable(shd_raw)); // R6
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_q_n)
    clear_i |=> cnt_free == '0 && cnt_raw == '0); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    !clear_i && cnt_raw == TOP |=> cnt_raw == TOP); // R8
endmodule

bind deadtime_scaler dts_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .clear_i  (clear_i),
  .latch_i  (latch_i),
  .veto_i   (veto_i),
  .cnt_free (cnt_q[0]),
  .cnt_gated(cnt_q[1]),
  .cnt_raw  (cnt_q[2]),
  .shd_raw  (shadow_q[2])
);

// File: tb/deadtime_scaler_tb.sv
`timescale 1ns/1ps
module deadtime_scaler_tb;
  localparam int CW   = 8;
  localparam int NSRC = 16;
  localparam int DIV  = 10;
  localparam int NCNT = 4 + NSRC;
  localparam int SW   = $clog2(NCNT);
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n, veto, raw, live, clr, lat;
  logic [NSRC-1:0] src;
  logic [SW-1:0]   sel;
  logic [CW-1:0]   rd;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  deadtime_scaler #(.CNT_W(CW), .NUM_SRC(NSRC), .PULSE_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .veto_i(veto), .raw_trig_i(raw),
    .live_trig_i(live), .src_i(src), .clear_i(clr), .latch_i(lat),
    .rd_sel_i(sel), .rd_data_o(rd)
  );

  // behavioural reference model
  int mcnt[NCNT];
  int mshad[NCNT];
  bit mprev[NSRC+2];
  int rel = 0, mdiv = 0;

  always @(posedge clk) begin
    bit tk;
    bit inc[NCNT];
    bit cur[NSRC+2];
    if (!rst_n) begin
      rel = 0; mdiv = 0;
      foreach (mcnt[i]) begin mcnt[i] = 0; mshad[i] = 0; end
      foreach (mprev[i]) mprev[i] = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      cur[0] = raw; cur[1] = live;
      for (int i = 0; i < NSRC; i++) cur[2+i] = src[i];
      tk = (mdiv == DIV - 1);
      inc[0] = tk; inc[1] = tk && !veto;
      for (int i = 0; i < NSRC + 2; i++) inc[2+i] = cur[i] && !mprev[i];
      if (lat) foreach (mcnt[i]) mshad[i] = mcnt[i];
      if (clr) begin
        foreach (mcnt[i]) mcnt[i] = 0;
        mdiv = 0;
      end else begin
        foreach (mcnt[i]) if (inc[i] && mcnt[i] < MAXV) mcnt[i]++;
        mdiv = tk ? 0 : mdiv + 1;
      end
      foreach (mprev[i]) mprev[i] = cur[i];
    end
  end

  task automatic check(string tag, logic [CW-1:0] got, int exp);
    tests++;
    if (got !== CW'(exp)) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic string tag_of(int idx);
    if (idx == 0) return "R2 free pulser";
    if (idx == 1) return "R3 gated pulser";
    if (idx < 4)  return "R4 trigger count";
    if (idx < NCNT) return "R5 source count";
    return "R9 out of range";
  endfunction

  // every-cycle compare of the read port against the model (R6)
  always @(posedge clk) begin
    #2;
    if (rst_n && !done)
      check("R6 read path", rd, (int'(sel) < NCNT) ? mshad[sel] : 0);
  end

  task automatic idle();
    veto = 0; raw = 0; live = 0; src = '0; clr = 0; lat = 0;
  endtask

  task automatic pulse_latch();
    @(negedge clk); lat = 1;
    @(negedge clk); lat = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic read_one(int idx, string tag, int exp);
    @(negedge clk); sel = SW'(idx); #1;
    check(tag, rd, exp);
  endtask

  task automatic read_all();
    for (int i = 0; i < NCNT; i++) read_one(i, tag_of(i), mshad[i]);
  endtask

  initial begin
    rst_n = 0; sel = '0; idle();
    repeat (3) @(negedge clk);
    #1 check("R1 reset read", rd, 0);
    @(negedge clk); rst_n = 1; raw = 1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); raw = 0;   // raw rose before first active edge: one count
    pulse_latch();
    read_one(2, "R1 count after release", 1);

    // random traffic
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if ($urandom % 6 == 0) veto = ~veto;
      raw  = 1'($urandom);
      live = 1'($urandom % 3 == 0);
      src  = NSRC'($urandom);
      sel  = SW'($urandom);
      lat  = ($urandom % 16 == 0);
      clr  = ($urandom % 64 == 0);
    end
    idle();
    pulse_latch();
    read_all();

    // pulser period and veto gating after a clear
    @(negedge clk); clr = 1; veto = 1;
    @(negedge clk); clr = 0;
    repeat (30) @(negedge clk);
    lat = 1;
    @(negedge clk); lat = 0; veto = 0;
    read_one(0, "R2 three ticks in 30 edges", 3);
    read_one(1, "R3 veto held high blocks ticks", 0);
    repeat (25) @(negedge clk);
    pulse_latch();
    read_one(1, "R3 gated counts without veto", mshad[1]);
    read_one(0, "R2 free count", mshad[0]);

    // level held through a clear
    @(negedge clk); src[3] = 1;
    repeat (3) @(negedge clk);
    clr = 1;
    @(negedge clk); clr = 0;
    repeat (15) @(negedge clk);
    pulse_latch();
    read_one(7, "R10 held level not recounted after clear", 0);
    src[3] = 0;
    @(negedge clk); src[3] = 1;
    repeat (20) @(negedge clk);
    pulse_latch();
    read_one(7, "R5 long level counts once", 1);
    src[3] = 0;

    // latch and clear on the same edge
    repeat (3) begin @(negedge clk); live = 1; @(negedge clk); live = 0; end
    @(negedge clk); lat = 1; clr = 1;
    @(negedge clk); lat = 0; clr = 0;
    read_one(3, "R7 latch captures pre-clear value", 3);
    pulse_latch();
    read_one(3, "R7 counter zero after clear", 0);
    read_one(4 + 3, "R7 source zero after clear", 0);

    // saturation
    for (int k = 0; k < 300; k++) begin
      @(negedge clk); raw = 1;
      @(negedge clk); raw = 0;
    end
    pulse_latch();
    read_one(2, "R8 saturates", MAXV);
    read_one(3, "R4 live idle stays zero", 0);

    // out-of-range selects
    for (int i = NCNT; i < (1 << SW); i++) read_one(i, "R9 out of range", 0);

    // shadows hold without latch
    read_one(2, "R6 before traffic", MAXV);
    pulse_clear();
    repeat (20) @(negedge clk);
    read_one(2, "R6 shadow unchanged without latch", MAXV);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule